// File: doc/BRIEF.md
# Fractional reference clock divider

This block produces a programmable reference clock from one of three source clocks. Software picks a source by code, sets an integer divisor N and a 9-bit trim M, and turns the output on. The output period is 2·(N + M/512) source periods. The half-period length is normally N source cycles. A phase accumulator adds M to a 9-bit running sum at each half-period boundary, and each overflow makes the next half-period one source cycle longer. When N is zero the selected source passes straight through and M is ignored.

Every source is carried into the block as a one-cycle tick strobe that is synchronous to the core clock, with one tick for each source rising edge. A divided output therefore appears as a level that toggles on counted ticks. In pass-through mode the output is a copy of the tick, delayed by one register.

New N and M values are held in the register file until software sets a self-clearing switch bit. A change of source or ratio is committed only when the output is low and a half-period has just ended, so the output never produces a runt pulse. A busy flag stays high while a commit is outstanding. The enable, the output enable and the other control fields can be set or cleared through two write aliases, so no read-modify-write is needed.

Top module: `refclk_gen`

## Requirements
- R1: With M = 0 and N ≥ 1, the k-th toggle of `ref_out` after enabling follows the k·N-th counted tick of the selected source. This gives an output period of 2·N source cycles.
- R2: With trim M, the k-th toggle follows tick number k·N + floor((k−1)·M/512).
- R3: With N = 0, `ref_out` is high in exactly the core cycles that follow a tick of the selected source, whatever the value of M.
- R4: Source code 0 selects `sys_tick`, code 7 selects `pll_tick` and code 8 selects `ext_tick`. Any other code gives no output.
- R5: The control word at offset 0x00 holds these fields: source code in bits [3:0], busy in bit 8, switch request in bit 9, output enable in bit 12, enable in bit 15 and N in bits [30:16]. All other bits read 0. The trim word at offset 0x10 holds M in bits [31:23], and its other bits read 0.
- R6: A write to offset 0x08 ORs the data into the writable control fields. A write to offset 0x04 clears the control fields whose bits are 1 in the data. A read from either alias returns the control word.
- R7: Writes to N and M leave the running ratio unchanged until a 1 is written to bit 9 through the base or set address. Bit 9 clears by itself when the new ratio takes effect.
- R8: Bit 8 reads 1 while a switch request or a source change is still waiting for commit, and reads 0 afterwards.
- R9: `ref_out` is low whenever the enable or the output enable is 0.
- R10: A commit takes place only when the output is low. After a commit, `ref_out` is low.
- R11: After reset, both registers read 0 and `ref_out` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | ADDR_W | Register byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from `bus_addr` |
| sys_tick | input | 1 | System clock edge strobe (code 0) |
| pll_tick | input | 1 | PLL clock edge strobe (code 7) |
| ext_tick | input | 1 | External reference edge strobe (code 8) |
| ref_out | output | 1 | Reference clock output |

## Verification
Several properties are checked on every cycle by assertions: a disabled divider drives its level low, every commit leaves the output low, a served switch request clears itself, the active divisor moves only on a commit, and the half-period counter never passes the divisor. Other behaviours only the bench scenarios can show: the exact tick on which each toggle lands under different N, M and source choices, the pass-through mode, the field layout and the two aliases, the fact that N written without a switch request leaves a running output unchanged, and the new period once the switch completes.

// File: rtl/refclk_pkg.sv
package refclk_pkg;
  localparam int DATA_W   = 32;
  localparam int SEL_W    = 4;
  localparam int N_W      = 15;
  localparam int M_W      = 9;
  localparam int SEL_LSB  = 0;
  localparam int BUSY_BIT = 8;
  localparam int SW_BIT   = 9;
  localparam int OE_BIT   = 12;
  localparam int EN_BIT   = 15;
  localparam int N_LSB    = 16;
  localparam int M_LSB    = 23;

  typedef enum logic [1:0] {SRC_NONE, SRC_SYS, SRC_PLL, SRC_EXT} src_e;

  typedef struct packed {
    logic [N_W-1:0]   n;
    logic             en;
    logic             oe;
    logic [SEL_W-1:0] sel;
  } ctrl_t;

  function automatic src_e decode_src(logic [SEL_W-1:0] code);
    case (code)
      4'd0:    return SRC_SYS;
      4'd7:    return SRC_PLL;
      4'd8:    return SRC_EXT;
      default: return SRC_NONE;
    endcase
  endfunction

  // one accumulator step: {carry, new sum}
  function automatic logic [M_W:0] trim_step(logic [M_W-1:0] acc, logic [M_W-1:0] m);
    return {1'b0, acc} + {1'b0, m};
  endfunction

  // half-period length in source ticks
  function automatic logic [N_W:0] half_len(logic [N_W-1:0] n, logic carry);
    return {1'b0, n} + {{N_W{1'b0}}, carry};
  endfunction
endpackage

// File: rtl/refclk_regs.sv
module refclk_regs
  import refclk_pkg::*;
#(
  parameter int ADDR_W   = 5,
  parameter int OFF_BASE = 0,
  parameter int OFF_CLR  = 4,
  parameter int OFF_SET  = 8,
  parameter int OFF_TRIM = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  input  logic              commit,
  input  logic [SEL_W-1:0]  act_sel,
  output ctrl_t             cfg_q,
  output logic [M_W-1:0]    m_q,
  output logic              sw_pend,
  output logic              sw_req,
  output logic              busy
);
  logic hit_base, hit_clr, hit_set, hit_trim;
  logic [DATA_W-1:0] ctrl_img, trim_img;

  assign hit_base = (addr == ADDR_W'(OFF_BASE));
  assign hit_clr  = (addr == ADDR_W'(OFF_CLR));
  assign hit_set  = (addr == ADDR_W'(OFF_SET));
  assign hit_trim = (addr == ADDR_W'(OFF_TRIM));
  assign sw_req   = we && (hit_base || hit_set) && wdata[SW_BIT];
  assign busy     = sw_pend || (cfg_q.sel != act_sel);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q   <= '0;
      m_q     <= '0;
      sw_pend <= 1'b0;
    end else begin
      if (sw_req)      sw_pend <= 1'b1;
      else if (commit) sw_pend <= 1'b0;
      if (we && hit_base) begin
        cfg_q.sel <= wdata[SEL_LSB +: SEL_W];
        cfg_q.oe  <= wdata[OE_BIT];
        cfg_q.en  <= wdata[EN_BIT];
        cfg_q.n   <= wdata[N_LSB +: N_W];
      end else if (we && hit_set) begin
        cfg_q.sel <= cfg_q.sel | wdata[SEL_LSB +: SEL_W];
        cfg_q.oe  <= cfg_q.oe  | wdata[OE_BIT];
        cfg_q.en  <= cfg_q.en  | wdata[EN_BIT];
        cfg_q.n   <= cfg_q.n   | wdata[N_LSB +: N_W];
      end else if (we && hit_clr) begin
        cfg_q.sel <= cfg_q.sel & ~wdata[SEL_LSB +: SEL_W];
        cfg_q.oe  <= cfg_q.oe  & ~wdata[OE_BIT];
        cfg_q.en  <= cfg_q.en  & ~wdata[EN_BIT];
        cfg_q.n   <= cfg_q.n   & ~wdata[N_LSB +: N_W];
      end
      if (we && hit_trim) m_q <= wdata[M_LSB +: M_W];
    end
  end

  always_comb begin
    ctrl_img = '0;
    ctrl_img[SEL_LSB +: SEL_W] = cfg_q.sel;
    ctrl_img[BUSY_BIT]         = busy;
    ctrl_img[SW_BIT]           = sw_pend;
    ctrl_img[OE_BIT]           = cfg_q.oe;
    ctrl_img[EN_BIT]           = cfg_q.en;
    ctrl_img[N_LSB +: N_W]     = cfg_q.n;
    trim_img = '0;
    trim_img[M_LSB +: M_W]     = m_q;
    if (hit_base || hit_clr || hit_set) rdata = ctrl_img;
    else if (hit_trim)                  rdata = trim_img;
    else                                rdata = '0;
  end
endmodule

// File: rtl/refclk_srcmux.sv
module refclk_srcmux
  import refclk_pkg::*;
(
  input  logic [SEL_W-1:0] act_sel,
  input  logic             sys_tick,
  input  logic             pll_tick,
  input  logic             ext_tick,
  output logic             tick
);
  logic [3:0] src_vec;
  src_e       src;

  assign src_vec = {ext_tick, pll_tick, sys_tick, 1'b0};
  assign src     = decode_src(act_sel);
  assign tick    = src_vec[src];
endmodule

// File: rtl/refclk_fracdiv.sv
module refclk_fracdiv
  import refclk_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [SEL_W-1:0] cfg_sel,
  input  logic [N_W-1:0]   cfg_n,
  input  logic [M_W-1:0]   cfg_m,
  input  logic             sw_pend,
  input  logic             tick,
  output logic [SEL_W-1:0] act_sel,
  output logic [N_W-1:0]   act_n,
  output logic [N_W:0]     cnt_q,
  output logic             commit,
  output logic             out_q
);
  logic [M_W-1:0] act_m, acc_q;
  logic [N_W:0]   cur_len;
  logic [M_W:0]   step;
  logic [N_W-1:0] new_n;
  logic           safe, boundary;

  assign step     = trim_step(acc_q, act_m);
  assign new_n    = sw_pend ? cfg_n : act_n;
  assign safe     = !en || (!out_q && cnt_q == '0);
  assign commit   = (sw_pend || (cfg_sel != act_sel)) && safe;
  assign boundary = tick && (cnt_q == cur_len - 1'b1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_sel <= '0;
      act_n   <= '0;
      act_m   <= '0;
      acc_q   <= '0;
      cnt_q   <= '0;
      cur_len <= '0;
      out_q   <= 1'b0;
    end else if (commit) begin
      act_sel <= cfg_sel;
      if (sw_pend) begin
        act_n <= cfg_n;
        act_m <= cfg_m;
      end
      cur_len <= half_len(new_n, 1'b0);
      acc_q   <= '0;
      cnt_q   <= '0;
      out_q   <= 1'b0;
    end else if (!en) begin
      cur_len <= half_len(act_n, 1'b0);
      acc_q   <= '0;
      cnt_q   <= '0;
      out_q   <= 1'b0;
    end else if (act_n == '0) begin
      out_q <= tick;
    end else if (boundary) begin
      out_q   <= ~out_q;
      cnt_q   <= '0;
      acc_q   <= step[M_W-1:0];
      cur_len <= half_len(act_n, step[M_W]);
    end else if (tick) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/refclk_gen.sv
module refclk_gen
  import refclk_pkg::*;
#(
  parameter int ADDR_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic              sys_tick,
  input  logic              pll_tick,
  input  logic              ext_tick,
  output logic              ref_out
);
  ctrl_t            cfg_q;
  logic [M_W-1:0]   m_q;
  logic [SEL_W-1:0] act_sel;
  logic [N_W-1:0]   act_n;
  logic [N_W:0]     cnt_q;
  logic             sw_pend, sw_req, busy, commit, out_q, tick, en_q;

  assign en_q    = cfg_q.en;
  assign ref_out = en_q && cfg_q.oe && out_q;

  refclk_regs #(.ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .we(bus_we), .addr(bus_addr), .wdata(bus_wdata),
    .rdata(bus_rdata), .commit(commit), .act_sel(act_sel), .cfg_q(cfg_q),
    .m_q(m_q), .sw_pend(sw_pend), .sw_req(sw_req), .busy(busy)
  );

  refclk_srcmux u_mux (
    .act_sel(act_sel), .sys_tick(sys_tick), .pll_tick(pll_tick),
    .ext_tick(ext_tick), .tick(tick)
  );

  refclk_fracdiv u_div (
    .clk(clk), .rst_n(rst_n), .en(en_q), .cfg_sel(cfg_q.sel), .cfg_n(cfg_q.n),
    .cfg_m(m_q), .sw_pend(sw_pend), .tick(tick), .act_sel(act_sel),
    .act_n(act_n), .cnt_q(cnt_q), .commit(commit), .out_q(out_q)
  );
endmodule

// File: rtl/refclk_gen_chk.sv
module refclk_gen_chk
  import refclk_pkg::*;
(
  input logic           clk,
  input logic           rst_n,
  input logic           en_q,
  input logic           commit,
  input logic           sw_pend,
  input logic           sw_req,
  input logic           out_q,
  input logic           ref_out,
  input logic [N_W-1:0] act_n,
  input logic [N_W:0]   cnt_q
);
  // R9
  disabled_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en_q |=> !out_q);
  // R10
  commit_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    commit |=> !ref_out);
  // R7
  sw_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (commit && sw_pend && !sw_req) |=> !sw_pend);
  // R7
  ratio_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !commit |=> $stable(act_n));
  // R7
  sw_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sw_pend) |-> $past(commit));
  // R1
  cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= {1'b0, act_n});
endmodule

bind refclk_gen refclk_gen_chk u_chk (
  .clk(clk), .rst_n(rst_n), .en_q(en_q), .commit(commit), .sw_pend(sw_pend),
  .sw_req(sw_req), .out_q(out_q), .ref_out(ref_out), .act_n(act_n), .cnt_q(cnt_q)
);

// File: tb/tb_refclk_gen.sv
module tb_refclk_gen;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_we = 1'b0;
  logic [4:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        sys_tick = 1'b0, pll_tick = 1'b0, ext_tick = 1'b0;
  logic        ref_out;

  always #4 clk = ~clk;

  refclk_gen dut (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .sys_tick(sys_tick),
    .pll_tick(pll_tick), .ext_tick(ext_tick), .ref_out(ref_out)
  );

  int    checks = 0, fails = 0, cyc_n = 0, tcount = 0, mode = 0, bsel = 0;
  bit    live = 0, prev_tick_live = 0, done = 0;
  logic  prev_ref = 1'b0;
  string mreq = "R1";
  int    exp_q[$];

  function automatic bit src_tick(int code, int n);
    case (code)
      0:       return (n % 3) == 0;
      7:       return (n % 2) == 0;
      8:       return (n % 5) == 0;
      default: return 1'b0;
    endcase
  endfunction

  function automatic bit [31:0] cw(int sel, bit sw, bit oe, bit en, int n);
    return (32'(n) << 16) | (32'(en) << 15) | (32'(oe) << 12) | (32'(sw) << 9) | 32'(sel);
  endfunction

  task automatic chk(bit ok, string req, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // one core cycle: monitor samples, then stimulus drives ticks
  task automatic cyc();
    int e;
    bit t;
    @(negedge clk);
    cyc_n++;
    if (mode == 1 && ref_out !== prev_ref) begin
      if (exp_q.size() == 0) chk(1'b0, mreq, "unexpected toggle", tcount, -1);
      else begin
        e = exp_q.pop_front();
        chk(tcount == e, mreq, "toggle tick", tcount, e);
      end
    end
    if (mode == 2) chk(ref_out === prev_tick_live, "R3", "pass-through level", ref_out, prev_tick_live);
    prev_ref = ref_out;
    sys_tick = src_tick(0, cyc_n);
    pll_tick = src_tick(7, cyc_n);
    ext_tick = src_tick(8, cyc_n);
    t = src_tick(bsel, cyc_n);
    if (live && t) tcount++;
    prev_tick_live = live && t;
  endtask

  task automatic wr(bit [4:0] a, bit [31:0] d);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    cyc();
    bus_we = 1'b0;
  endtask

  task automatic rd(bit [4:0] a, output bit [31:0] v);
    bus_addr = a;
    #1;
    v = bus_rdata;
  endtask

  task automatic cfg(int sel, int n, int m, bit oe);
    bsel = sel;
    wr(5'h10, 32'(m) << 23);
    wr(5'h00, cw(sel, 1'b1, oe, 1'b0, n));
    repeat (3) cyc();
  endtask

  task automatic enable();
    live = 1'b1; tcount = 0;
    wr(5'h08, 32'h8000);
  endtask

  task automatic disable_div();
    mode = 0;
    wr(5'h04, 32'h8000);
    live = 1'b0;
    repeat (3) cyc();
  endtask

  // scoreboard driver: push toggle ticks k*N + floor((k-1)*M/512)
  task automatic push_exp(int n, int m, int k_max);
    for (int k = 1; k <= k_max; k++) exp_q.push_back(k * n + ((k - 1) * m) / 512);
  endtask

  task automatic drain(string req);
    int guard = 0;
    while (exp_q.size() != 0 && guard < 3000) begin cyc(); guard++; end
    chk(exp_q.size() == 0, req, "toggles left", exp_q.size(), 0);
    exp_q.delete();
  endtask

  task automatic ratio_run(string req, int sel, int n, int m, int k_max);
    cfg(sel, n, m, 1'b1);
    mreq = req;
    push_exp(n, m, k_max);
    prev_ref = ref_out;
    mode = 1;
    enable();
    drain(req);
    disable_div();
  endtask

  initial begin
    #1600000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc_n, 0);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    bit [31:0] v;
    int hi, t0, t1, guard;
    logic lp;
    repeat (3) cyc();
    // R11 reset state
    rd(5'h00, v); chk(v == 0, "R11", "ctrl after reset", v, 0);
    rd(5'h10, v); chk(v == 0, "R11", "trim after reset", v, 0);
    chk(ref_out == 1'b0, "R11", "output after reset", ref_out, 0);
    rst_n = 1'b1;
    repeat (2) cyc();

    // R5 field layout and readback
    wr(5'h00, cw(8, 1'b0, 1'b1, 1'b0, 5) | 32'h8000_0020);
    cyc();
    rd(5'h00, v); chk(v == cw(8, 1'b0, 1'b1, 1'b0, 5), "R5", "ctrl readback", v, cw(8, 1'b0, 1'b1, 1'b0, 5));
    wr(5'h10, (32'h1AB << 23) | 32'h007F_FFFF);
    rd(5'h10, v); chk(v == (32'h1AB << 23), "R5", "trim readback", v, 32'h1AB << 23);

    // R1 integer ratios; R4 code 7 selects pll_tick
    ratio_run("R1", 7, 3, 0, 8);
    ratio_run("R4", 7, 1, 0, 6);
    // R2 fractional trim; R4 codes 0 and 8
    ratio_run("R2", 0, 2, 200, 12);
    ratio_run("R2", 8, 1, 511, 10);

    // R3 pass-through, trim ignored
    cfg(8, 0, 300, 1'b1);
    prev_tick_live = 1'b0;
    mode = 2;
    enable();
    repeat (30) cyc();
    disable_div();

    // R4 unused source code gives no output
    cfg(3, 1, 0, 1'b1);
    enable();
    hi = 0;
    repeat (40) begin cyc(); if (ref_out) hi++; end
    chk(hi == 0, "R4", "high cycles with code 3", hi, 0);
    disable_div();

    // R6 aliases, R9 output enable gating
    bsel = 7;
    wr(5'h00, cw(7, 1'b0, 1'b0, 1'b0, 2));
    repeat (2) cyc();
    wr(5'h08, 32'h9000);
    rd(5'h00, v); chk(v == cw(7, 1'b0, 1'b1, 1'b1, 2), "R6", "set alias", v, cw(7, 1'b0, 1'b1, 1'b1, 2));
    rd(5'h08, v); chk(v == cw(7, 1'b0, 1'b1, 1'b1, 2), "R6", "read via set alias", v, cw(7, 1'b0, 1'b1, 1'b1, 2));
    wr(5'h04, 32'h1000);
    rd(5'h04, v); chk(v == cw(7, 1'b0, 1'b0, 1'b1, 2), "R6", "clear alias", v, cw(7, 1'b0, 1'b0, 1'b1, 2));
    hi = 0;
    repeat (30) begin cyc(); if (ref_out) hi++; end
    chk(hi == 0, "R9", "high cycles with output enable off", hi, 0);
    wr(5'h04, 32'h8000);
    rd(5'h00, v); chk(v == cw(7, 1'b0, 1'b0, 1'b0, 2), "R6", "clear enable", v, cw(7, 1'b0, 1'b0, 1'b0, 2));
    repeat (3) cyc();

    // R7 new N has no effect until the switch request
    cfg(7, 2, 0, 1'b1);
    mreq = "R7";
    push_exp(2, 0, 16);
    prev_ref = ref_out;
    mode = 1;
    enable();
    repeat (20) cyc();
    wr(5'h00, cw(7, 1'b0, 1'b1, 1'b1, 6));
    drain("R7");
    rd(5'h00, v); chk(v[9] == 1'b0, "R7", "switch bit before request", v[9], 0);
    mode = 0;
    wr(5'h08, 32'h0200);
    rd(5'h00, v); chk(v[9] == 1'b1, "R7", "switch bit after request", v[9], 1);
    chk(v[8] == 1'b1, "R8", "busy while switch pending", v[8], 1);
    guard = 0;
    do begin cyc(); rd(5'h00, v); guard++; end while (v[9] && guard < 200);
    chk(v[9] == 1'b0, "R7", "switch bit self-clears", v[9], 0);
    lp = ref_out; t0 = -1; t1 = -1; guard = 0;
    while (t1 < 0 && guard < 500) begin
      cyc(); guard++;
      if (ref_out && !lp) begin if (t0 < 0) t0 = cyc_n; else t1 = cyc_n; end
      lp = ref_out;
    end
    chk(t1 - t0 == 24, "R7", "period after switch (cycles)", t1 - t0, 24);

    // R8 busy during a source change, R10 commit while low
    guard = 0;
    while (!ref_out && guard < 100) begin cyc(); guard++; end
    wr(5'h00, cw(0, 1'b0, 1'b1, 1'b1, 6));
    rd(5'h00, v); chk(v[8] == 1'b1, "R8", "busy during source change", v[8], 1);
    chk(ref_out == 1'b1, "R10", "output held while high", ref_out, 1);
    guard = 0;
    do begin cyc(); rd(5'h00, v); guard++; end while (v[8] && guard < 200);
    chk(v[8] == 1'b0, "R8", "busy clears", v[8], 0);
    chk(ref_out == 1'b0, "R10", "output low at commit", ref_out, 0);
    disable_div();

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule